// File: doc/BRIEF.md
# Multi-bank programmable clock divider

This block takes one fast clock, which stands in for the output of an on-chip oscillator, and produces four divided clock outputs: bank A, bank B, bank C and a feedback output. A shared pre-divider first divides the counting source by 2 or 4. Each bank then divides the pre-divided rate by its own selectable ratio. Every output comes from a flop on the fast clock, so all outputs share one timing reference and their rising edges line up.

All counting is done with a single clock. Dividers advance on an enable pulse instead of on derived clocks. In normal operation the pulse is present on every fast-clock cycle. When bypass is selected, a slower reference input is sampled on the fast clock and each of its rising edges becomes one count step. The reference then drives the whole divider chain in place of the fast clock.

An active-low master reset also serves as the output enable. While it is low, every counter is cleared and every output is held low. Select lines are captured during reset. After release, a select change is held back until the next frame boundary. At that point every counter wraps at once, so outputs never show a runt pulse, and the new ratios start together on one common rising edge.

Top module: `mbank_clkdiv`

## Requirements
- R1: While `mrst_oe_n_i` is low, every output (`qa_o`, `qb_o`, `qc_o`, `qfb_o`) is low from the first clock edge that samples it low, and all counters are cleared.
- R2: On the first clock edge that samples `mrst_oe_n_i` high, all four outputs go high together.
- R3: Without bypass, `qa_o` has a period of P×DA fast cycles. P is 2 when `pre_sel_i`=0 and 4 when `pre_sel_i`=1. DA is 2 when `a_sel_i`=0 and 4 when `a_sel_i`=1.
- R4: `qb_o` has a period of P×DB. DB is 2 when `b_sel_i`=0 and 4 when it is 1, and it is independent of `a_sel_i`.
- R5: `qc_o` has a period of P×DC. DC is 4 when `c_sel_i`=0 and 6 when it is 1.
- R6: `qfb_o` has a period of P×DF. The 2-bit `fb_sel_i` gives DF: 0 gives 4, 1 gives 6, 2 gives 8 and 3 gives 12.
- R7: Each output is high for exactly the first half of its period, counted from its rising edge, for every ratio including 6 and 12.
- R8: Select lines are applied only at a frame boundary. The frame lasts 24 pre-divided periods (24×P fast cycles of the active setting) and is counted from release. Up to the last edge of a frame, outputs follow the old setting. At that edge all outputs fall. On the next edge all outputs rise with the new setting.
- R9: When `byp_sel_i`=1, each rising edge of `ref_i` (as sampled by the fast clock) counts as one step in place of a fast cycle. Every output period therefore becomes the reference period times P times the bank ratio. The 50% duty cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock standing in for the oscillator output |
| mrst_oe_n_i | input | 1 | Active-low master reset and output enable |
| ref_i | input | 1 | Bypass reference, sampled on clk_i |
| byp_sel_i | input | 1 | 1: count reference edges instead of fast cycles |
| pre_sel_i | input | 1 | Pre-divider select (0: ÷2, 1: ÷4) |
| a_sel_i | input | 1 | Bank A select (0: ÷2, 1: ÷4) |
| b_sel_i | input | 1 | Bank B select (0: ÷2, 1: ÷4) |
| c_sel_i | input | 1 | Bank C select (0: ÷4, 1: ÷6) |
| fb_sel_i | input | 2 | Feedback select (0: ÷4, 1: ÷6, 2: ÷8, 3: ÷12) |
| qa_o | output | 1 | Bank A divided output |
| qb_o | output | 1 | Bank B divided output |
| qc_o | output | 1 | Bank C divided output |
| qfb_o | output | 1 | Feedback divided output |

## Verification
The bench compares every output against a waveform it computes itself, cycle by cycle, for all 64 select combinations. A wrong ratio, an off-by-one half period, or a 3/6 or 6/12 duty split that is not 50% shows up as a single misplaced edge.

Randomized mid-run select changes, including one applied on the very last edge of a frame, target the frame boundary. A design that applied selects at once would produce a runt or stretched pulse before the boundary. A design that missed the boundary would keep the old ratio for a whole extra frame.

Bypass runs at several reference periods check the edge counting. Double-counting a reference edge, or counting its level instead of its edge, would shorten or distort the measured period and high time.

// File: rtl/mbd_pkg.sv
`timescale 1ns/1ps
package mbd_pkg;

  // Greatest common divisor, usable in constant expressions.
  function automatic int unsigned gcd_f(input int unsigned a, input int unsigned b);
    int unsigned x;
    int unsigned y;
    int unsigned t;
    x = a;
    y = b;
    while (y != 0) begin
      t = y;
      y = x % y;
      x = t;
    end
    return x;
  endfunction

  function automatic int unsigned lcm_f(input int unsigned a, input int unsigned b);
    return (a / gcd_f(a, b)) * b;
  endfunction

  function automatic int unsigned max_f(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Active select set, captured in reset and at frame boundaries.
  typedef struct packed {
    logic       pre;
    logic       a;
    logic       b;
    logic       c;
    logic [1:0] fb;
  } mbd_sel_t;

endpackage

// File: rtl/mbd_tick_gen.sv
`timescale 1ns/1ps
// Produces the count-enable pulse: every cycle normally, or one pulse per
// sampled rising edge of the bypass reference.
module mbd_tick_gen (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic byp_i,
  input  logic ref_i,
  output logic tick_o
);

  logic ref_q;
  logic ref_d;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      ref_q <= 1'b0;
      ref_d <= 1'b0;
    end else begin
      ref_q <= ref_i;
      ref_d <= ref_q;
    end
  end

  assign tick_o = byp_i ? (ref_q & ~ref_d) : 1'b1;

  // A reference edge yields one pulse only: never two in a row.
  AST_ONE_PULSE_PER_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (byp_i && tick_o) |=> !(byp_i && tick_o)); // R9

endmodule

// File: rtl/mbd_prediv.sv
`timescale 1ns/1ps
// Shared pre-divider: wraps every DIV0 or DIV1 count-enable pulses.
module mbd_prediv #(
  parameter int unsigned DIV0 = 2,
  parameter int unsigned DIV1 = 4
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic tick_i,
  input  logic sel_i,
  output logic wrap_o
);

  localparam int unsigned DMAX = mbd_pkg::max_f(DIV0, DIV1);
  localparam int unsigned CW   = (DMAX > 2) ? $clog2(DMAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_c;

  assign last_c = sel_i ? CW'(DIV1 - 1) : CW'(DIV0 - 1);
  assign wrap_o = tick_i & (cnt_q == last_c);

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == last_c) ? '0 : cnt_q + 1'b1;
    end
  end

  // The select only moves at a wrap, so the count never overruns it.
  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= last_c); // R8

endmodule

// File: rtl/mbd_align.sv
`timescale 1ns/1ps
// Frame counter: marks the pulse on which every bank wraps at once and
// applies pending selects only there.
module mbd_align #(
  parameter int unsigned FRAME = 24
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             pre_wrap_i,
  input  mbd_pkg::mbd_sel_t sel_i,
  output mbd_pkg::mbd_sel_t act_o,
  output logic             align_o
);

  localparam int unsigned FW = (FRAME > 2) ? $clog2(FRAME) : 1;

  logic [FW-1:0] frm_q;

  assign align_o = pre_wrap_i & (frm_q == FW'(FRAME - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      frm_q <= '0;
      act_o <= sel_i;
    end else begin
      if (pre_wrap_i) begin
        frm_q <= (frm_q == FW'(FRAME - 1)) ? '0 : frm_q + 1'b1;
      end
      if (align_o) begin
        act_o <= sel_i;
      end
    end
  end

  AST_SEL_HELD_OFF_FRAME: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !align_o |=> $stable(act_o)); // R8

endmodule

// File: rtl/mbd_bank_div.sv
`timescale 1ns/1ps
// One output bank: counts pre-divider wraps modulo the selected ratio and
// drives a retimed 50% duty output (high in the first half of the count).
module mbd_bank_div #(
  parameter int unsigned SEL_W = 1,
  parameter int unsigned DIV0  = 2,
  parameter int unsigned DIV1  = 4,
  parameter int unsigned DIV2  = 4,
  parameter int unsigned DIV3  = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             adv_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clk_o
);

  localparam int unsigned DMAX = mbd_pkg::max_f(mbd_pkg::max_f(DIV0, DIV1),
                                                mbd_pkg::max_f(DIV2, DIV3));
  localparam int unsigned CW   = (DMAX > 2) ? $clog2(DMAX) : 1;

  logic [1:0]    idx;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_c;
  logic [CW-1:0] half_c;

  assign idx = 2'(sel_i);

  always_comb begin
    case (idx)
      2'd0:    begin last_c = CW'(DIV0 - 1); half_c = CW'(DIV0 / 2); end
      2'd1:    begin last_c = CW'(DIV1 - 1); half_c = CW'(DIV1 / 2); end
      2'd2:    begin last_c = CW'(DIV2 - 1); half_c = CW'(DIV2 / 2); end
      default: begin last_c = CW'(DIV3 - 1); half_c = CW'(DIV3 / 2); end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      clk_o <= 1'b0;
    end else begin
      if (adv_i) begin
        cnt_q <= (cnt_q == last_c) ? '0 : cnt_q + 1'b1;
      end
      clk_o <= (cnt_q < half_c);
    end
  end

  AST_BANK_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= last_c); // R8

endmodule

// File: rtl/mbank_clkdiv.sv
`timescale 1ns/1ps
module mbank_clkdiv #(
  parameter int unsigned PRE_DIV0 = 2,
  parameter int unsigned PRE_DIV1 = 4,
  parameter int unsigned AB_DIV0  = 2,
  parameter int unsigned AB_DIV1  = 4,
  parameter int unsigned C_DIV0   = 4,
  parameter int unsigned C_DIV1   = 6,
  parameter int unsigned FB_DIV0  = 4,
  parameter int unsigned FB_DIV1  = 6,
  parameter int unsigned FB_DIV2  = 8,
  parameter int unsigned FB_DIV3  = 12
) (
  input  logic       clk_i,
  input  logic       mrst_oe_n_i,
  input  logic       ref_i,
  input  logic       byp_sel_i,
  input  logic       pre_sel_i,
  input  logic       a_sel_i,
  input  logic       b_sel_i,
  input  logic       c_sel_i,
  input  logic [1:0] fb_sel_i,
  output logic       qa_o,
  output logic       qb_o,
  output logic       qc_o,
  output logic       qfb_o
);

  import mbd_pkg::*;

  // Frame length in pre-divided periods: every bank ratio divides it.
  localparam int unsigned FRAME =
    lcm_f(lcm_f(lcm_f(AB_DIV0, AB_DIV1), lcm_f(C_DIV0, C_DIV1)),
          lcm_f(lcm_f(FB_DIV0, FB_DIV1), lcm_f(FB_DIV2, FB_DIV3)));
  localparam int unsigned NAB = 2;

  mbd_sel_t   pin_sel;
  mbd_sel_t   act_sel;
  logic       tick;
  logic       pre_wrap;
  logic       align;
  logic [NAB-1:0] ab_sel;
  logic [NAB-1:0] ab_q;

  assign pin_sel = '{pre: pre_sel_i, a: a_sel_i, b: b_sel_i, c: c_sel_i, fb: fb_sel_i};

  mbd_tick_gen u_tick (
    .clk_i   (clk_i),
    .rst_n_i (mrst_oe_n_i),
    .byp_i   (byp_sel_i),
    .ref_i   (ref_i),
    .tick_o  (tick)
  );

  mbd_prediv #(.DIV0(PRE_DIV0), .DIV1(PRE_DIV1)) u_pre (
    .clk_i   (clk_i),
    .rst_n_i (mrst_oe_n_i),
    .tick_i  (tick),
    .sel_i   (act_sel.pre),
    .wrap_o  (pre_wrap)
  );

  mbd_align #(.FRAME(FRAME)) u_align (
    .clk_i      (clk_i),
    .rst_n_i    (mrst_oe_n_i),
    .pre_wrap_i (pre_wrap),
    .sel_i      (pin_sel),
    .act_o      (act_sel),
    .align_o    (align)
  );

  assign ab_sel[0] = act_sel.a;
  assign ab_sel[1] = act_sel.b;

  // Banks A and B share one ratio pair, each with its own select.
  for (genvar g = 0; g < NAB; g++) begin : g_ab
    mbd_bank_div #(.SEL_W(1), .DIV0(AB_DIV0), .DIV1(AB_DIV1),
                   .DIV2(AB_DIV1), .DIV3(AB_DIV1)) u_bank (
      .clk_i   (clk_i),
      .rst_n_i (mrst_oe_n_i),
      .adv_i   (pre_wrap),
      .sel_i   (ab_sel[g]),
      .clk_o   (ab_q[g])
    );
  end

  mbd_bank_div #(.SEL_W(1), .DIV0(C_DIV0), .DIV1(C_DIV1),
                 .DIV2(C_DIV1), .DIV3(C_DIV1)) u_bank_c (
    .clk_i   (clk_i),
    .rst_n_i (mrst_oe_n_i),
    .adv_i   (pre_wrap),
    .sel_i   (act_sel.c),
    .clk_o   (qc_o)
  );

  mbd_bank_div #(.SEL_W(2), .DIV0(FB_DIV0), .DIV1(FB_DIV1),
                 .DIV2(FB_DIV2), .DIV3(FB_DIV3)) u_bank_fb (
    .clk_i   (clk_i),
    .rst_n_i (mrst_oe_n_i),
    .adv_i   (pre_wrap),
    .sel_i   (act_sel.fb),
    .clk_o   (qfb_o)
  );

  assign qa_o = ab_q[0];
  assign qb_o = ab_q[1];

  AST_DARK_IN_RESET: assert property (@(posedge clk_i)
    !mrst_oe_n_i |=> ({qa_o, qb_o, qc_o, qfb_o} == 4'b0000)); // R1

  AST_COMMON_START: assert property (@(posedge clk_i)
    $rose(mrst_oe_n_i) |=> ({qa_o, qb_o, qc_o, qfb_o} == 4'b1111)); // R2

  AST_FRAME_EDGE_LOW: assert property (@(posedge clk_i) disable iff (!mrst_oe_n_i)
    align |=> ({qa_o, qb_o, qc_o, qfb_o} == 4'b0000)); // R8

endmodule

// File: tb/mbank_clkdiv_tb_top.sv
`timescale 1ns/1ps
module mbank_clkdiv_tb_top;

  logic       clk = 1'b0;
  logic       mrst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic       byp = 1'b0;
  logic       pre_s = 1'b0;
  logic       a_s = 1'b0;
  logic       b_s = 1'b0;
  logic       c_s = 1'b0;
  logic [1:0] fb_s = 2'b00;
  logic       qa, qb, qc, qfb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int ref_per = 0;
  int ref_ph  = 0;

  always #2.5 clk = ~clk;

  mbank_clkdiv dut_i (
    .clk_i       (clk),
    .mrst_oe_n_i (mrst_n),
    .ref_i       (ref_in),
    .byp_sel_i   (byp),
    .pre_sel_i   (pre_s),
    .a_sel_i     (a_s),
    .b_sel_i     (b_s),
    .c_sel_i     (c_s),
    .fb_sel_i    (fb_s),
    .qa_o        (qa),
    .qb_o        (qb),
    .qc_o        (qc),
    .qfb_o       (qfb)
  );

  // Reference generator: one high sample out of every ref_per cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (ref_per < 2) begin
        ref_in = 1'b0;
        ref_ph = 0;
      end else begin
        ref_in = (ref_ph == 0);
        ref_ph = (ref_ph + 1) % ref_per;
      end
    end
  end

  // Config bits: [0] pre, [1] a, [2] b, [3] c, [5:4] fb.
  function automatic int pre_div(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int bank_pd(input int b, input logic [5:0] cf);
    int p;
    p = pre_div(cf[0]);
    case (b)
      0: return p * (cf[1] ? 4 : 2);
      1: return p * (cf[2] ? 4 : 2);
      2: return p * (cf[3] ? 6 : 4);
      default: begin
        case (cf[5:4])
          2'd0: return p * 4;
          2'd1: return p * 6;
          2'd2: return p * 8;
          default: return p * 12;
        endcase
      end
    endcase
  endfunction

  function automatic logic exp_out(input int pd, input int k);
    return ((k % pd) < (pd / 2));
  endfunction

  function automatic logic out_of(input int b);
    case (b)
      0: return qa;
      1: return qb;
      2: return qc;
      default: return qfb;
    endcase
  endfunction

  task automatic drive(input logic [5:0] cf);
    pre_s = cf[0];
    a_s   = cf[1];
    b_s   = cf[2];
    c_s   = cf[3];
    fb_s  = cf[5:4];
  endtask

  task automatic check_dark(input string tag);
    checks++;
    if ({qa, qb, qc, qfb} !== 4'b0000) begin
      fails++;
      $display("FAIL %s outputs in reset: got %b expected 0000", tag, {qa, qb, qc, qfb});
    end
  endtask

  // Cycle-exact waveform compare; chg<0 means no select change.
  task automatic run_wave(input logic [5:0] oc, input logic [5:0] nc,
                          input int chg, input bit is_chg);
    int f;
    int n;
    int bad [4];
    int kbad [4];
    logic gbad [4];
    logic ebad [4];
    string tags [4];
    tags = '{"R3/R7", "R4/R7", "R5/R7", "R6/R7"};
    for (int b = 0; b < 4; b++) begin
      bad[b] = 0; kbad[b] = 0; gbad[b] = 1'b0; ebad[b] = 1'b0;
    end
    @(negedge clk);
    mrst_n = 1'b0;
    byp = 1'b0;
    ref_per = 0;
    drive(oc);
    @(negedge clk);
    check_dark("R1");
    repeat (2) @(negedge clk);
    f = 24 * pre_div(oc[0]);
    n = f + 110;
    mrst_n = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (k == chg) drive(nc);
      @(negedge clk);
      if (k == 0) begin
        checks++;
        if ({qa, qb, qc, qfb} !== 4'b1111) begin
          fails++;
          $display("FAIL R2 first edge after release: got %b expected 1111", {qa, qb, qc, qfb});
        end
      end
      for (int b = 0; b < 4; b++) begin
        logic e;
        e = (k < f) ? exp_out(bank_pd(b, oc), k) : exp_out(bank_pd(b, nc), k - f);
        if (out_of(b) !== e) begin
          if (bad[b] == 0) begin
            kbad[b] = k; gbad[b] = out_of(b); ebad[b] = e;
          end
          bad[b]++;
        end
      end
    end
    for (int b = 0; b < 4; b++) begin
      checks++;
      if (bad[b] != 0) begin
        fails++;
        $display("FAIL %s bank %0d cfg %h->%h cycle %0d: got %b expected %b",
                 is_chg ? "R8" : tags[b], b, oc, nc, kbad[b], gbad[b], ebad[b]);
      end
    end
  endtask

  // Measure high time and period of one bank starting from a rising edge.
  task automatic measure(input int b, input int pd, input string tag);
    logic prev;
    int hi;
    int lo;
    int guard;
    prev = out_of(b);
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if ((prev == 1'b0 && out_of(b) == 1'b1) || guard > 3000) break;
      prev = out_of(b);
    end
    hi = 1;
    while (guard < 6000) begin
      @(negedge clk); guard++;
      if (out_of(b) == 1'b1) hi++; else break;
    end
    lo = 1;
    while (guard < 9000) begin
      @(negedge clk); guard++;
      if (out_of(b) == 1'b0) lo++; else break;
    end
    checks++;
    if (hi != pd / 2 || hi + lo != pd) begin
      fails++;
      $display("FAIL %s bypass bank %0d: got high %0d period %0d expected high %0d period %0d",
               tag, b, hi, hi + lo, pd / 2, pd);
    end
  endtask

  task automatic run_byp(input logic [5:0] cf, input int r);
    @(negedge clk);
    mrst_n = 1'b0;
    byp = 1'b1;
    ref_per = r;
    drive(cf);
    repeat (3) @(negedge clk);
    check_dark("R1");
    mrst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int b = 0; b < 4; b++) begin
      measure(b, r * bank_pd(b, cf), "R9");
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1C));
    repeat (3) @(negedge clk);
    // All select combinations: ratios R3..R6 and duty R7.
    for (int c = 0; c < 64; c++) begin
      run_wave(6'(c), 6'(c), -1, 1'b0);
    end
    // Directed frame-boundary corners (R8): earliest and last possible change.
    run_wave(6'h00, 6'h3F, 1, 1'b1);
    run_wave(6'h3F, 6'h00, 24 * 4 - 1, 1'b1);
    run_wave(6'h2A, 6'h15, 24 * 2 - 1, 1'b1);
    // Random select changes inside the first frame (R8).
    for (int i = 0; i < 12; i++) begin
      logic [5:0] oc;
      logic [5:0] nc;
      int f;
      oc = 6'($urandom_range(0, 63));
      nc = 6'($urandom_range(0, 63));
      f  = 24 * pre_div(oc[0]);
      run_wave(oc, nc, int'($urandom_range(1, f - 1)), 1'b1);
    end
    // Bypass counting (R9): directed longest case, then random.
    run_byp(6'h3F, 5);
    run_byp(6'h00, 2);
    for (int i = 0; i < 4; i++) begin
      run_byp(6'($urandom_range(0, 63)), int'($urandom_range(2, 5)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion expected completion within 150000 cycles");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule